// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block decides which of 14 interrupt sources a small 8-bit CPU should service next. Sources 0 and 1 come from external pins, and each pin can be set to level or edge sampling. Sources 2 to 13 are request flags from peripherals. Each source has its own enable bit and a two-bit priority, and a global enable can mask every source at once. The CPU pulses a strobe at each instruction boundary. On that strobe the controller registers a request line, the index of the winning source, and the level of that source.

The CPU acknowledges a request when it takes the vector. The acknowledge marks the level of that source as in service. A return pulse retires the most recent level. While a level is in service, only a source with a strictly higher level can raise a new request, so handlers nest up to four deep. When the core is asleep, an enabled external pin drives a wake-up output.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A source is pending only when its request, its bit in `src_en` and `glob_en` are all high. With `glob_en` low, no strobe raises `irq`.
- R2: A source's level is `{prio_hi[i], prio_lo[i]}`, where 3 is the highest. Among the pending sources, the one with the highest level wins.
- R3: When several pending sources share the highest level, the one with the lowest index wins.
- R4: A winner raises `irq` only if its level is strictly greater than the highest level in service. While level 3 is in service, no source raises `irq`.
- R5: An acknowledge while `irq` is high clears `irq` on the next edge and marks the winner's level as in service. A `reti` pulse removes only the highest in-service level.
- R6: `irq` and `irq_id` change only at an edge where `insn_start` or `ack` is high. On `insn_start`, both take the arbitration result; if nothing is eligible, `irq` is 0.
- R7: In edge mode (`ext_edge[k]`=1), pin k sets a latched flag when one clock sample reads 1 and the next reads 0. A rising pin sets nothing. Acknowledging source k clears the flag.
- R8: In level mode (`ext_edge[k]`=0), source k requests exactly while the sampled pin reads 0. Nothing is latched.
- R9: `wake` is high only while `sleep` is high and an external source is requesting, enabled by `src_en` and enabled by `glob_en`. Peripheral requests never drive `wake`.
- R10: After reset, `irq`, `irq_id` and `wake` are 0 and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 2 | External interrupt pins, sampled every clock (sources 0,1) |
| ext_edge | input | 2 | Per-pin mode: 1 edge, 0 level |
| per_req | input | 12 | Peripheral request flags for sources 2..13 (bit j is source j+2) |
| src_en | input | 14 | Per-source enable |
| glob_en | input | 1 | Global enable |
| prio_lo | input | 14 | Low bit of each source's level |
| prio_hi | input | 14 | High bit of each source's level |
| insn_start | input | 1 | Instruction-boundary strobe |
| ack | input | 1 | Vector taken |
| reti | input | 1 | Return-from-interrupt pulse |
| sleep | input | 1 | Core in idle or power-down |
| irq | output | 1 | Interrupt request to the CPU |
| irq_id | output | 4 | Index of the winning source |
| wake | output | 1 | Wake-up request |

## Verification
The assertions assume that the CPU raises `ack` only while `irq` is high. They also assume that `ack` and `reti` never share a cycle, and that `reti` arrives only while some level is in service. The bench drives each of these as a single-cycle pulse at a separate step. It issues a return only after a matching acknowledge, and it never overlaps an acknowledge with a strobe. The priority sweep never acknowledges, so the in-service mask stays empty while tie-breaking and level selection are checked against an arithmetic ranking key.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int LVL_W = 2;
    localparam int N_LVL = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/nic_ext_cond.sv
module nic_ext_cond #(
    parameter int N_EXT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] edge_mode,
    input  logic [N_EXT-1:0] clr,
    output logic [N_EXT-1:0] req
);
    typedef struct packed {
        logic [N_EXT-1:0] smp;
        logic [N_EXT-1:0] prv;
        logic [N_EXT-1:0] flg;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = pin;
        st_d.prv = st_q.smp;
        for (int k = 0; k < N_EXT; k++) begin
            if (edge_mode[k])
                st_d.flg[k] = (st_q.prv[k] & ~st_q.smp[k]) | (st_q.flg[k] & ~clr[k]);
            else
                st_d.flg[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.smp <= '1;
            st_q.prv <= '1;
            st_q.flg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_EXT; g++) begin : g_req
        assign req[g] = edge_mode[g] ? st_q.flg[g] : ~st_q.smp[g];
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int N_SRC = 14,
    parameter int IDW   = 4
) (
    input  logic [N_SRC-1:0] pend,
    input  logic [N_SRC-1:0] prio_lo,
    input  logic [N_SRC-1:0] prio_hi,
    output logic             found,
    output logic [IDW-1:0]   win_id,
    output lvl_t             win_lvl
);
    always_comb begin
        lvl_t cand;
        found   = 1'b0;
        win_id  = '0;
        win_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            cand = {prio_hi[i], prio_lo[i]};
            if (pend[i] && (!found || cand > win_lvl)) begin
                found   = 1'b1;
                win_id  = IDW'(i);
                win_lvl = cand;
            end
        end
    end
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  lvl_t             push_lvl,
    input  logic             pop,
    output logic [N_LVL-1:0] mask,
    output logic             top_valid,
    output lvl_t             top_lvl
);
    typedef struct packed {
        logic [N_LVL-1:0] mask;
    } svc_t;

    svc_t sv_d, sv_q;

    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < N_LVL; i++)
            if (sv_q.mask[i]) top_lvl = lvl_t'(i);
        top_valid = |sv_q.mask;
        sv_d = sv_q;
        if (push)
            sv_d.mask[push_lvl] = 1'b1;
        else if (pop && top_valid)
            sv_d.mask[top_lvl] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv_q <= '0;
        else        sv_q <= sv_d;
    end

    assign mask = sv_q.mask;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_SRC = 14,
    parameter int N_EXT = 2,
    localparam int IDW   = $clog2(N_SRC),
    localparam int N_PER = N_SRC - N_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_pin,
    input  logic [N_EXT-1:0] ext_edge,
    input  logic [N_PER-1:0] per_req,
    input  logic [N_SRC-1:0] src_en,
    input  logic             glob_en,
    input  logic [N_SRC-1:0] prio_lo,
    input  logic [N_SRC-1:0] prio_hi,
    input  logic             insn_start,
    input  logic             ack,
    input  logic             reti,
    input  logic             sleep,
    output logic             irq,
    output logic [IDW-1:0]   irq_id,
    output logic             wake
);
    typedef struct packed {
        logic           irq;
        logic [IDW-1:0] id;
        lvl_t           lvl;
    } out_t;

    out_t             ou_d, ou_q;
    logic [N_EXT-1:0] ext_req;
    logic [N_EXT-1:0] ext_clr;
    logic [N_SRC-1:0] raw_req;
    logic [N_SRC-1:0] pend;
    logic             found;
    logic [IDW-1:0]   win_id;
    lvl_t             win_lvl;
    logic [N_LVL-1:0] isr_mask;
    logic             top_valid;
    lvl_t             top_lvl;
    logic             ack_take;
    logic             eligible;

    assign ack_take = ack & ou_q.irq;

    for (genvar g = 0; g < N_EXT; g++) begin : g_clr
        assign ext_clr[g] = ack_take && (ou_q.id == IDW'(g));
    end

    nic_ext_cond #(.N_EXT(N_EXT)) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .edge_mode (ext_edge),
        .clr       (ext_clr),
        .req       (ext_req)
    );

    assign raw_req = {per_req, ext_req};

    for (genvar s = 0; s < N_SRC; s++) begin : g_pend
        assign pend[s] = raw_req[s] & src_en[s] & glob_en;
    end

    nic_arbiter #(.N_SRC(N_SRC), .IDW(IDW)) u_arb (
        .pend    (pend),
        .prio_lo (prio_lo),
        .prio_hi (prio_hi),
        .found   (found),
        .win_id  (win_id),
        .win_lvl (win_lvl)
    );

    nic_inservice u_isv (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_take),
        .push_lvl  (ou_q.lvl),
        .pop       (reti),
        .mask      (isr_mask),
        .top_valid (top_valid),
        .top_lvl   (top_lvl)
    );

    assign eligible = found && (!top_valid || (win_lvl > top_lvl));

    always_comb begin
        ou_d = ou_q;
        if (ack_take) begin
            ou_d.irq = 1'b0;
        end else if (insn_start) begin
            ou_d.irq = eligible;
            ou_d.id  = win_id;
            ou_d.lvl = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ou_q <= '0;
        else        ou_q <= ou_d;
    end

    assign irq    = ou_q.irq;
    assign irq_id = ou_q.id;
    assign wake   = sleep & glob_en & (|(ext_req & src_en[N_EXT-1:0]));
endmodule

// File: rtl/nic_chk.sv
module nic_chk
    import nic_pkg::*;
#(
    parameter int IDW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             glob_en,
    input logic             insn_start,
    input logic             ack,
    input logic             reti,
    input logic             sleep,
    input logic             irq,
    input logic [IDW-1:0]   irq_id,
    input logic             wake,
    input logic [N_LVL-1:0] isr_mask
);
    // R6
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_start && !ack) |=> ($stable(irq) && $stable(irq_id)));

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> !irq);

    // R5
    ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> (isr_mask != '0));

    // R5
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && (isr_mask != '0)) |=>
        ($countones(isr_mask) + 1 == $countones($past(isr_mask))));

    // R1
    glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(glob_en));

    // R4
    top_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_start && !ack && isr_mask[N_LVL-1]) |=> !irq);

    // R9
    wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |-> !wake);
endmodule

bind nest_irq_ctrl nic_chk #(.IDW(IDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en),
    .insn_start (insn_start),
    .ack        (ack),
    .reti       (reti),
    .sleep      (sleep),
    .irq        (irq),
    .irq_id     (irq_id),
    .wake       (wake),
    .isr_mask   (isr_mask)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
    localparam int NS = 14;
    localparam int NE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] ext_pin = '1;
    logic [NE-1:0] ext_edge = '0;
    logic [NS-NE-1:0] per_req = '0;
    logic [NS-1:0] src_en = '1;
    logic          glob_en = 1'b1;
    logic [NS-1:0] prio_lo = '0;
    logic [NS-1:0] prio_hi = '0;
    logic          insn_start = 1'b0;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          sleep = 1'b0;
    logic          irq;
    logic [3:0]    irq_id;
    logic          wake;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_abcd;

    always #5 clk = ~clk;

    nest_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge(ext_edge),
        .per_req(per_req), .src_en(src_en), .glob_en(glob_en),
        .prio_lo(prio_lo), .prio_hi(prio_hi), .insn_start(insn_start),
        .ack(ack), .reti(reti), .sleep(sleep),
        .irq(irq), .irq_id(irq_id), .wake(wake)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        insn_start = 1'b1; tick(); insn_start = 1'b0;
    endtask

    task automatic take();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic ret();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    task automatic set_lvl(int idx, int lv);
        prio_lo[idx] = lv[0];
        prio_hi[idx] = lv[1];
    endtask

    function automatic logic [31:0] nxt(logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int best_key;
        int best_id;
        int key;
        tick(2);
        rst_n = 1'b1;
        tick();
        // R10 reset state
        chk("R10 irq", irq, 0);
        chk("R10 irq_id", irq_id, 0);
        chk("R10 wake", wake, 0);

        // R1 R2 R3 sweep, in-service mask stays empty
        for (int t = 0; t < 400; t++) begin
            seed = nxt(seed); per_req = seed[27:16];
            seed = nxt(seed); src_en = seed[29:16] | seed[17:4];
            seed = nxt(seed); prio_lo = (t % 3 == 0) ? '0 : seed[29:16];
            seed = nxt(seed); prio_hi = (t % 5 == 0) ? '0 : seed[29:16];
            glob_en = (t % 7 != 0);
            best_key = -1; best_id = 0;
            for (int i = NE; i < NS; i++) begin
                if (per_req[i-NE] && src_en[i] && glob_en) begin
                    key = (2 * prio_hi[i] + prio_lo[i]) * 16 + (15 - i);
                    if (key > best_key) begin best_key = key; best_id = i; end
                end
            end
            strobe();
            chk("R1 R2 R3 irq", irq, best_key >= 0);
            if (best_key >= 0) chk("R2 R3 irq_id", irq_id, best_id);
            if (t % 50 == 1) begin
                per_req = ~per_req;
                tick(3);
                // R6 outputs hold without strobe
                chk("R6 irq hold", irq, best_key >= 0);
                if (best_key >= 0) chk("R6 id hold", irq_id, best_id);
            end
        end

        // nesting R4 R5
        per_req = '0; src_en = '1; glob_en = 1'b1; prio_lo = '0; prio_hi = '0;
        set_lvl(5, 1); set_lvl(3, 1); set_lvl(7, 2); set_lvl(9, 3); set_lvl(11, 3);
        per_req[5-NE] = 1'b1;
        strobe();
        chk("R2 nest first", irq, 1);
        chk("R2 nest id", irq_id, 5);
        take();
        chk("R5 ack clears irq", irq, 0);
        per_req[5-NE] = 1'b0;
        per_req[3-NE] = 1'b1;
        strobe();
        chk("R4 same level blocked", irq, 0);
        per_req[7-NE] = 1'b1;
        strobe();
        chk("R4 higher preempts", irq, 1);
        chk("R4 higher id", irq_id, 7);
        take();
        per_req[7-NE] = 1'b0;
        per_req[9-NE] = 1'b1;
        strobe();
        chk("R4 level3 preempts", irq_id, 9);
        take();
        per_req[9-NE] = 1'b0;
        per_req[11-NE] = 1'b1;
        strobe();
        chk("R4 top level blocks", irq, 0);
        ret();
        strobe();
        chk("R5 reti pops top", irq, 1);
        chk("R5 reti id", irq_id, 11);
        per_req[11-NE] = 1'b0;
        ret();
        strobe();
        chk("R5 level1 still busy", irq, 0);
        ret();
        strobe();
        chk("R5 all popped", irq, 1);
        chk("R5 all popped id", irq_id, 3);
        per_req = '0;
        strobe();
        chk("R6 strobe idle", irq, 0);

        // level mode R8 on pin 0
        prio_lo = '0; prio_hi = '0;
        ext_edge = 2'b00;
        ext_pin[0] = 1'b0;
        tick(2);
        strobe();
        chk("R8 level low requests", irq, 1);
        chk("R8 level id", irq_id, 0);
        ext_pin[0] = 1'b1;
        tick(2);
        strobe();
        chk("R8 not latched", irq, 0);

        // edge mode R7
        ext_pin[0] = 1'b0;
        tick(2);
        ext_edge[0] = 1'b1;
        tick(2);
        ext_pin[0] = 1'b1;
        tick(3);
        strobe();
        chk("R7 rising ignored", irq, 0);
        ext_pin[0] = 1'b0;
        tick(3);
        ext_pin[0] = 1'b1;
        tick(3);
        strobe();
        chk("R7 fall latched", irq, 1);
        chk("R7 fall id", irq_id, 0);
        take();
        ret();
        strobe();
        chk("R7 ack clears flag", irq, 0);
        ext_edge = '0;

        // wake R9 on pin 1
        sleep = 1'b1;
        ext_pin[1] = 1'b0;
        tick(2);
        chk("R9 wake on pin", wake, 1);
        src_en[1] = 1'b0; #1;
        chk("R9 disabled no wake", wake, 0);
        src_en[1] = 1'b1; glob_en = 1'b0; #1;
        chk("R9 global off no wake", wake, 0);
        glob_en = 1'b1; sleep = 1'b0; #1;
        chk("R9 awake no wake", wake, 0);
        ext_pin[1] = 1'b1;
        per_req[4] = 1'b1; sleep = 1'b1;
        tick(2);
        chk("R9 peripheral no wake", wake, 0);
        sleep = 1'b0; per_req = '0;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule